// File: doc/BRIEF.md
# SD/MMC Command Issue Front End

This block is the command side of an SD/MMC host controller. Software first loads a 32-bit argument and then writes a 16-bit command word. Writing the command word checks the request and, if it is legal, starts the command. The block sends the 48-bit command frame, with its CRC7, one bit per clock on the command line. It then waits for the card's reply and gathers the reply's payload bits into a 128-bit response register.

The response register shifts left as payload bits arrive. Earlier short responses therefore move into the upper bits, and the newest one sits in bits 31:0. The block signals response end. For a busy-type response it signals busy end instead, which comes once the card releases data line 0. It also reports four kinds of fault, each on its own flag: no start bit, a wrong echoed index, a CRC mismatch and a bad end bit. A command word written while a command is running, or one that asks for an impossible combination, is refused with an illegal-access pulse. The data transfer engine and card clock generation are outside this block. One card bit is exchanged per clock.

Top module: `cmd_front`

## Requirements
- R1: After reset the block is idle: `busy`, `cmd_oe` and every flag are low, `resp` is zero and every decoded field is zero.
- R2: The command word fields are: bits 5:0 index, bits 7:6 class (value 1 = application command), bits 10:8 response type, bit 11 data phase, bit 12 read (1) or write (0), bit 13 multi-block (1) or single-block (0). The `dec_*` outputs reflect the last accepted command word from the cycle after it is written.
- R3: An accepted command drives `cmd_oe` high for exactly 48 cycles, starting the cycle after the write. `cmd_out` carries, MSB first: 0, 1, the 6-bit index, the argument from the most recent argument write, the CRC7 (x^7+x^3+1, zero seed) of those 40 bits, then 1.
- R4: With response type 3 (none), `resp_end` pulses in the cycle after the last frame bit, and the block returns to idle without listening for a reply.
- R5: A command word written while `busy` is high yields a one-cycle `illegal` pulse in the next cycle and does not alter the running command.
- R6: A command word written while idle that has the data bit set with index 12 or with type 3, or that has a type of 0, 1 or 2, yields a one-cycle `illegal` pulse and launches nothing.
- R7: For types 4, 5 and 7, reply bits 8 to 39 (start bit = bit 0) shift into `resp` from the LSB, so the newest 32-bit payload ends in bits 31:0 and earlier contents move up by 32.
- R8: For type 6 the reply is 136 bits long. `resp` is cleared when the start bit arrives, and reply bits 8 to 127 then fill bits 119:0, leaving bits 127:120 zero.
- R9: After the frame, 64 consecutive cycles with `cmd_in` high and no start bit end the command with an `err_to` pulse and no `resp_end`. A start bit in the 64th waiting cycle is still accepted.
- R10: `err_crc` pulses together with response completion when the reply CRC7 is wrong. For 48-bit replies the CRC covers reply bits 0 to 39, and for 136-bit replies bits 8 to 127. Type 7 is never checked.
- R11: For types 4 and 5, `err_idx` pulses at completion when reply bits 2 to 7 differ from the sent index.
- R12: `err_end` pulses at completion when the last reply bit is 0.
- R13: For type 5, after the reply the block stays busy while `dat0_in` is low. `resp_end` pulses in the cycle after `dat0_in` is sampled high. For the other types, `resp_end` pulses in the cycle after the last reply bit, alongside any error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one card bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| arg_we | input | 1 | Argument write strobe |
| arg_wdata | input | 32 | Argument value |
| cmd_we | input | 1 | Command word write strobe; launches a command |
| cmd_wdata | input | 16 | Command word |
| cmd_in | input | 1 | Command line from the card |
| dat0_in | input | 1 | Data line 0, low while the card is busy |
| cmd_out | output | 1 | Command line bit toward the card |
| cmd_oe | output | 1 | Command line drive enable |
| busy | output | 1 | A command is in progress |
| resp | output | 128 | Response shift register |
| resp_end | output | 1 | One-cycle pulse: response end or busy end |
| illegal | output | 1 | One-cycle pulse: refused command write |
| err_to | output | 1 | One-cycle pulse: no response start bit |
| err_idx | output | 1 | One-cycle pulse: echoed index mismatch |
| err_crc | output | 1 | One-cycle pulse: response CRC mismatch |
| err_end | output | 1 | One-cycle pulse: response end bit was 0 |
| dec_data | output | 1 | Accepted command has a data phase |
| dec_read | output | 1 | Accepted command data direction is read |
| dec_multi | output | 1 | Accepted command is multi-block |
| dec_app | output | 1 | Accepted command is application class |

## Verification
All results are due at fixed distances from the rising edge that samples their cause. `illegal` and the decoded fields change one cycle after the write edge. Frame bit k is on `cmd_out` in the k-th cycle after that edge. `resp_end` and the error flags appear one cycle after the edge that samples the last reply bit or a high `dat0_in`. `err_to` follows the 64th waiting edge. The bench steps one rising edge at a time and advances a behavioural model of these events in the same step. It then compares every output, including the whole response register, at the following falling edge, so each expectation is checked in exactly the cycle it falls due.

// File: rtl/cmd_front.sv
module cmd_front #(
  parameter int RESP_TMO = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arg_we,
  input  logic [31:0]  arg_wdata,
  input  logic         cmd_we,
  input  logic [15:0]  cmd_wdata,
  input  logic         cmd_in,
  input  logic         dat0_in,
  output logic         cmd_out,
  output logic         cmd_oe,
  output logic         busy,
  output logic [127:0] resp,
  output logic         resp_end,
  output logic         illegal,
  output logic         err_to,
  output logic         err_idx,
  output logic         err_crc,
  output logic         err_end,
  output logic         dec_data,
  output logic         dec_read,
  output logic         dec_multi,
  output logic         dec_app
);
  localparam int TW = $clog2(RESP_TMO + 1);

  typedef enum logic [2:0] {S_IDLE, S_TX, S_WAIT, S_RX, S_BUSY} st_t;

  st_t          st;
  logic [31:0]  arg_q;
  logic [15:0]  cmd_q;
  logic [47:0]  txsr;
  logic [7:0]   cnt;
  logic [TW-1:0] tmo;
  logic [6:0]   rcrc;
  logic [5:0]   ridx;

  function automatic logic [6:0] crc7_of(input logic [39:0] d);
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int i = 39; i >= 0; i--) begin
      fb = d[i] ^ c[6];
      c  = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return c;
  endfunction

  wire [5:0] w_idx  = cmd_wdata[5:0];
  wire [2:0] w_rt   = cmd_wdata[10:8];
  wire       w_bad  = (w_rt < 3'd3) || (cmd_wdata[11] && (w_idx == 6'd12 || w_rt == 3'd3));
  wire       launch = cmd_we && (st == S_IDLE) && !w_bad;
  wire [39:0] hdr   = {2'b01, w_idx, arg_q};

  wire [2:0] rt      = cmd_q[10:8];
  wire       long_r  = (rt == 3'd6);
  wire [7:0] last_b  = long_r ? 8'd135 : 8'd47;
  wire       in_crc  = long_r ? (cnt >= 8'd8 && cnt <= 8'd134) : (cnt <= 8'd46);
  wire       in_pay  = (cnt >= 8'd8) && (long_r ? (cnt <= 8'd127) : (cnt <= 8'd39));
  wire       in_idx  = (cnt >= 8'd2) && (cnt <= 8'd7);
  wire       crc_fb  = cmd_in ^ rcrc[6];
  wire [6:0] crc_nx  = {rcrc[5:0], 1'b0} ^ (crc_fb ? 7'h09 : 7'h00);

  assign cmd_out   = txsr[47];
  assign cmd_oe    = (st == S_TX);
  assign busy      = (st != S_IDLE);
  assign dec_data  = cmd_q[11];
  assign dec_read  = cmd_q[12];
  assign dec_multi = cmd_q[13];
  assign dec_app   = (cmd_q[7:6] == 2'b01);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      arg_q    <= '0;
      cmd_q    <= '0;
      txsr     <= '0;
      cnt      <= '0;
      tmo      <= '0;
      rcrc     <= '0;
      ridx     <= '0;
      resp     <= '0;
      resp_end <= 1'b0;
      illegal  <= 1'b0;
      err_to   <= 1'b0;
      err_idx  <= 1'b0;
      err_crc  <= 1'b0;
      err_end  <= 1'b0;
    end else begin
      resp_end <= 1'b0;
      err_to   <= 1'b0;
      err_idx  <= 1'b0;
      err_crc  <= 1'b0;
      err_end  <= 1'b0;
      illegal  <= cmd_we && (st != S_IDLE || w_bad);
      if (arg_we) arg_q <= arg_wdata;
      case (st)
        S_IDLE: begin
          if (launch) begin
            cmd_q <= cmd_wdata;
            txsr  <= {hdr, crc7_of(hdr), 1'b1};
            cnt   <= '0;
            st    <= S_TX;
          end
        end
        S_TX: begin
          txsr <= {txsr[46:0], 1'b0};
          cnt  <= cnt + 8'd1;
          if (cnt == 8'd47) begin
            if (rt == 3'd3) begin
              st       <= S_IDLE;
              resp_end <= 1'b1;
            end else begin
              st  <= S_WAIT;
              tmo <= '0;
            end
          end
        end
        S_WAIT: begin
          if (!cmd_in) begin
            st   <= S_RX;
            cnt  <= 8'd1;
            rcrc <= '0;
            if (long_r) resp <= '0;
          end else if (tmo == TW'(RESP_TMO - 1)) begin
            st     <= S_IDLE;
            err_to <= 1'b1;
          end else begin
            tmo <= tmo + 1'b1;
          end
        end
        S_RX: begin
          cnt <= cnt + 8'd1;
          if (in_crc) rcrc <= crc_nx;
          if (in_idx) ridx <= {ridx[4:0], cmd_in};
          if (in_pay) resp <= {resp[126:0], cmd_in};
          if (cnt == last_b) begin
            err_end <= !cmd_in;
            err_crc <= (rt != 3'd7) && (rcrc != 7'd0);
            err_idx <= (rt == 3'd4 || rt == 3'd5) && (ridx != cmd_q[5:0]);
            if (rt == 3'd5) begin
              st <= S_BUSY;
            end else begin
              st       <= S_IDLE;
              resp_end <= 1'b1;
            end
          end
        end
        S_BUSY: begin
          if (dat0_in) begin
            st       <= S_IDLE;
            resp_end <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_FRAME_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_oe) |-> !cmd_out); // R3
  AST_CMD_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cmd_q)); // R5
  AST_REFUSED_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal && !$past(busy)) |-> !busy); // R6
  AST_LONG_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_end && cmd_q[10:8] == 3'd6) |-> (resp[127:120] == 8'd0)); // R8
  AST_TIMEOUT_ENDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    err_to |-> (!resp_end && !busy)); // R9
  AST_BUSY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st == S_BUSY) && !busy) |-> resp_end); // R13
endmodule

// File: tb/sim_cmd_front.sv
`timescale 1ns/1ps
module sim_cmd_front;
  localparam int TMO = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arg_we = 1'b0;
  logic [31:0] arg_wdata = '0;
  logic cmd_we = 1'b0;
  logic [15:0] cmd_wdata = '0;
  logic cmd_in = 1'b1;
  logic dat0_in = 1'b1;
  logic cmd_out, cmd_oe, busy, resp_end, illegal, err_to, err_idx, err_crc, err_end;
  logic dec_data, dec_read, dec_multi, dec_app;
  logic [127:0] resp;

  cmd_front #(.RESP_TMO(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .arg_we(arg_we), .arg_wdata(arg_wdata),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_in(cmd_in), .dat0_in(dat0_in),
    .cmd_out(cmd_out), .cmd_oe(cmd_oe), .busy(busy), .resp(resp),
    .resp_end(resp_end), .illegal(illegal), .err_to(err_to), .err_idx(err_idx),
    .err_crc(err_crc), .err_end(err_end), .dec_data(dec_data), .dec_read(dec_read),
    .dec_multi(dec_multi), .dec_app(dec_app));

  always #2.5 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  string req = "R1";

  logic exp_busy = 0, exp_oe = 0, exp_out = 0, exp_rend = 0, exp_ill = 0;
  logic exp_to = 0, exp_crc = 0, exp_idx = 0, exp_endb = 0;
  logic [3:0] exp_dec = '0;
  logic [127:0] exp_resp = '0;
  logic [31:0] arg_model = '0;
  logic rb [0:135];
  int rlen = 48;

  function automatic logic [6:0] bcrc(input int from, input int n);
    logic [6:0] c = '0;
    for (int i = from; i < from + n; i++) begin
      logic fb = rb[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'b0001001;
    end
    return c;
  endfunction

  function automatic logic [6:0] vcrc(input logic [39:0] d);
    logic [6:0] c = '0;
    for (int i = 39; i >= 0; i--) begin
      logic fb = d[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'b0001001;
    end
    return c;
  endfunction

  task automatic cyc();
    logic bad;
    @(posedge clk);
    @(negedge clk);
    compared++;
    bad = (busy !== exp_busy) || (cmd_oe !== exp_oe) || (exp_oe && cmd_out !== exp_out) ||
          (resp_end !== exp_rend) || (illegal !== exp_ill) || (err_to !== exp_to) ||
          (err_crc !== exp_crc) || (err_idx !== exp_idx) || (err_end !== exp_endb) ||
          (resp !== exp_resp) || ({dec_data, dec_read, dec_multi, dec_app} !== exp_dec);
    if (bad) begin
      mismatched++;
      $display("FAIL %s t=%0t actual busy=%b oe=%b out=%b end=%b ill=%b to=%b crc=%b idx=%b endb=%b dec=%b resp=%h | expected busy=%b oe=%b out=%b end=%b ill=%b to=%b crc=%b idx=%b endb=%b dec=%b resp=%h",
        req, $time, busy, cmd_oe, cmd_out, resp_end, illegal, err_to, err_crc, err_idx, err_end,
        {dec_data, dec_read, dec_multi, dec_app}, resp,
        exp_busy, exp_oe, exp_out, exp_rend, exp_ill, exp_to, exp_crc, exp_idx, exp_endb, exp_dec, exp_resp);
    end
    exp_rend = 0; exp_ill = 0; exp_to = 0; exp_crc = 0; exp_idx = 0; exp_endb = 0;
  endtask

  task automatic set_arg(input logic [31:0] a);
    arg_we = 1; arg_wdata = a;
    cyc();
    arg_we = 0;
    arg_model = a;
  endtask

  task automatic build48(input logic [5:0] ix, input logic [31:0] p);
    logic [6:0] c;
    rb[0] = 0; rb[1] = 0;
    for (int i = 0; i < 6; i++) rb[2+i] = ix[5-i];
    for (int i = 0; i < 32; i++) rb[8+i] = p[31-i];
    c = bcrc(0, 40);
    for (int i = 0; i < 7; i++) rb[40+i] = c[6-i];
    rb[47] = 1;
    rlen = 48;
  endtask

  task automatic build136(input logic [119:0] p);
    logic [6:0] c;
    rb[0] = 0; rb[1] = 0;
    for (int i = 2; i < 8; i++) rb[i] = 1;
    for (int i = 0; i < 120; i++) rb[8+i] = p[119-i];
    c = bcrc(8, 120);
    for (int i = 0; i < 7; i++) rb[128+i] = c[6-i];
    rb[135] = 1;
    rlen = 136;
  endtask

  task automatic run_cmd(input logic [15:0] w, input int gap, input int bsy, input int clash,
                         input logic ec, input logic ei, input logic ee);
    logic [2:0] rt = w[10:8];
    logic [39:0] h = {2'b01, w[5:0], arg_model};
    logic [47:0] frame = {h, vcrc(h), 1'b1};
    cmd_in = 1; dat0_in = 1;
    cmd_we = 1; cmd_wdata = w;
    exp_busy = 1; exp_oe = 1; exp_out = frame[47];
    exp_dec = {w[11], w[12], w[13], (w[7:6] == 2'b01)};
    cyc();
    cmd_we = 0;
    for (int k = 1; k < 48; k++) begin
      if (k == clash) begin
        cmd_we = 1; cmd_wdata = 16'h2C3F; exp_ill = 1;
      end
      exp_out = frame[47-k];
      cyc();
      cmd_we = 0;
    end
    exp_oe = 0;
    if (rt == 3'd3) begin
      exp_busy = 0; exp_rend = 1;
      cyc();
      return;
    end
    cyc();
    for (int g = 1; g <= gap; g++) begin
      if (g == TMO) begin
        exp_to = 1; exp_busy = 0;
      end
      cyc();
      if (g == TMO) return;
    end
    if (bsy > 0) dat0_in = 0;
    for (int j = 0; j < rlen; j++) begin
      cmd_in = rb[j];
      if (rt == 3'd6 && j == 0) exp_resp = '0;
      if (j >= 8 && j <= ((rt == 3'd6) ? 127 : 39)) exp_resp = {exp_resp[126:0], rb[j]};
      if (j == rlen - 1) begin
        exp_crc = ec; exp_idx = ei; exp_endb = ee;
        if (rt != 3'd5) begin
          exp_busy = 0; exp_rend = 1;
        end
      end
      cyc();
    end
    cmd_in = 1;
    if (rt == 3'd5) begin
      for (int b = 0; b < bsy; b++) cyc();
      dat0_in = 1; exp_busy = 0; exp_rend = 1;
      cyc();
    end
  endtask

  task automatic bad_write(input logic [15:0] w);
    cmd_we = 1; cmd_wdata = w; exp_ill = 1;
    cyc();
    cmd_we = 0;
    cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual run still going, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    req = "R1";
    cyc(); cyc();
    rst_n = 1;
    cyc();

    req = "R3";
    set_arg(32'h1234_5678);
    build48(6'd17, 32'hCAFE_0001);
    run_cmd(16'h0411, 5, 0, 0, 0, 0, 0);
    cyc();

    req = "R7";
    set_arg(32'hA5A5_0F0F);
    build48(6'd18, 32'h0BAD_F00D);
    run_cmd(16'h3C52, 0, 0, 0, 0, 0, 0);
    cyc();

    req = "R2";
    set_arg(32'h0000_0000);
    build48(6'd9, 32'h1357_9BDF);
    run_cmd(16'h2449, 2, 0, 0, 0, 0, 0);

    req = "R4";
    set_arg(32'hFFFF_FFFF);
    run_cmd(16'h0300, 0, 0, 0, 0, 0, 0);
    cyc();

    req = "R8";
    build136({30'h2AAA_5555, 30'h0123_4567, 30'h3FFF_0000, 30'h1C3C_3C3C});
    run_cmd(16'h0602, 3, 0, 0, 0, 0, 0);
    req = "R10";
    build136({4{30'h1234_5678}});
    rb[50] = ~rb[50];
    run_cmd(16'h0602, 0, 0, 0, 1, 0, 0);

    req = "R10";
    build48(6'd63, 32'h00FF_00FF);
    for (int i = 40; i < 47; i++) rb[i] = ~rb[i];
    run_cmd(16'h0701, 1, 0, 0, 0, 0, 0);
    build48(6'd13, 32'h8000_0001);
    rb[20] = ~rb[20];
    run_cmd(16'h040D, 1, 0, 0, 1, 0, 0);

    req = "R11";
    build48(6'd5, 32'h7777_1111);
    run_cmd(16'h0407, 1, 0, 0, 0, 1, 0);

    req = "R12";
    build48(6'd8, 32'h4242_2424);
    rb[47] = 0;
    run_cmd(16'h0408, 1, 0, 0, 0, 0, 1);

    req = "R9";
    run_cmd(16'h0410, TMO, 0, 0, 0, 0, 0);
    cyc();
    build48(6'd16, 32'hDEAD_BEEF);
    run_cmd(16'h0410, TMO - 1, 0, 0, 0, 0, 0);

    req = "R13";
    build48(6'd7, 32'h0000_0007);
    run_cmd(16'h0507, 2, 4, 0, 0, 0, 0);
    build48(6'd38, 32'h0000_0026);
    run_cmd(16'h0526, 0, 0, 0, 0, 0, 0);

    req = "R5";
    build48(6'd3, 32'h3333_3333);
    run_cmd(16'h0403, 1, 0, 10, 0, 0, 0);
    build48(6'd4, 32'h4444_4444);
    run_cmd(16'h0404, 1, 0, 47, 0, 0, 0);

    req = "R6";
    bad_write(16'h0C0C);
    bad_write(16'h0B05);
    bad_write(16'h0005);
    bad_write(16'h0205);
    cyc();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule